// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver with Overrun Protection

This block listens on a two-wire serial bus (clock line plus open-drain data line) as a receive-only slave with a 7-bit device address. It samples both lines into the system clock domain and finds frame starts and stops. It then shifts in an address byte. If the address matches and the direction bit asks for a write, the address byte and each following data byte go through a single-entry receive buffer to the host.

The host drains the buffer through a valid/ready output. `rx_valid_o` is high whenever the buffer holds an unread byte. A byte is consumed on any clock where `rx_valid_o` and `rx_ready_i` are both high. The engine never waits for the host. A byte that arrives while the buffer is still occupied is dropped, and the overrun flag is raised. The slave decides separately for each byte whether to pull the data line low in the ninth clock (acknowledge). It withholds the acknowledge whenever the buffer is occupied or the overrun flag is still set. An interrupt flag is raised once for each accepted byte. The overrun flag and the interrupt flag each have their own clear strobe.

Top module: `i2c_rx_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) begins a new address phase from any state. This includes a repeated START in the middle of a byte. A rising data line while the clock line is high (STOP) returns the engine to idle. Clock pulses seen in idle with no START are ignored.
- R2: When the address byte carries `dev_addr_i` in bits 7..1 and a 0 in bit 0, `rw_o` goes to 0. The whole address byte is then handled like a data byte: it is stored in the buffer and sets the full flag.
- R3: When bits 7..1 of the address byte differ from `dev_addr_i`, the slave gives no acknowledge and changes no flag or buffer content. It stays silent until the next START.
- R4: `sda_oe_o` is high during the ninth clock of an accepted byte exactly when both the full flag (`rx_valid_o`) and `ovf_o` were clear as the eighth bit arrived. It changes only while SCL is low.
- R5: `irq_o` is set by every accepted byte (a matching write address or a data byte after it). Only `irq_clr_i` clears it.
- R6: If `ovf_o` is set and the buffer is empty when a byte completes, the byte is still loaded and the full flag is set, but no acknowledge is given.
- R7: If the buffer is full when a byte completes, `ovf_o` is set and the buffer keeps its old contents.
- R8: `rx_valid_o` reflects the full flag and `rx_data_o` shows the buffer. A transfer (`rx_valid_o` and `rx_ready_i` high) clears the full flag.
- R9: Once set, `ovf_o` stays set until a cycle with `irq_clr_i`-independent `ovf_clr_i` high. Reading the buffer does not clear it.
- R10: Bits are taken most significant first, on the rising clock-line edge.
- R11: When the address matches and bit 0 is 1, `rw_o` goes to 1. No acknowledge is given and nothing is stored. The rest of the frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| dev_addr_i | input | 7 | Own 7-bit device address |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_valid_o | output | 1 | Buffer holds an unread byte |
| rx_ready_i | input | 1 | Host takes the buffered byte |
| ovf_o | output | 1 | Sticky overrun flag |
| ovf_clr_i | input | 1 | Clears the overrun flag |
| irq_o | output | 1 | Per-byte interrupt flag |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| rw_o | output | 1 | Direction bit of the last matching address |

## Verification
The acknowledge-timing check assumes that every SCL low phase lasts several system clocks after synchronisation. The data line may change only while SCL is low, except at START and STOP. The bench drives the bus with four-clock quarter periods and moves the data line only in the middle of the low phase. Host strobes are applied only between bytes, never in the cycle where a byte completes.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKWAIT,
    ST_ACKDRV,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sampler.sv
module i2c_rx_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sync[g] <= 1'b1;
          sda_sync[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sync[g] <= scl_i;
          sda_sync[g] <= sda_i;
        end else begin
          scl_sync[g] <= scl_sync[(g == 0) ? 0 : g-1];
          sda_sync[g] <= sda_sync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det) && !(scl_rise && scl_fall)); // R1
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              full_i,
  input  logic              ovf_i,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              rw_clr,
  output logic              rw_set,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e         state_q, after_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              is_addr_q, ack_q, oe_q;

  logic last_bit, addr_hit, accept;

  assign byte_val = {sh_q[BYTE_W-2:0], sda_s};
  assign last_bit = (state_q == ST_RECV) && scl_rise && (cnt_q == LAST_BIT)
                    && !start_det && !stop_det;
  assign addr_hit = (byte_val[BYTE_W-1:1] == dev_addr_i);
  assign accept   = !is_addr_q || (addr_hit && !byte_val[0]);

  assign byte_done = last_bit && accept;
  assign rw_clr    = last_bit && is_addr_q && addr_hit && !byte_val[0];
  assign rw_set    = last_bit && is_addr_q && addr_hit && byte_val[0];
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      after_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      is_addr_q <= 1'b0;
      ack_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_RECV;
      cnt_q     <= '0;
      is_addr_q <= 1'b1;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: if (scl_rise) begin
          sh_q  <= byte_val;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            state_q <= ST_ACKWAIT;
            ack_q   <= accept && !full_i && !ovf_i;
            after_q <= accept ? ST_RECV : ST_SKIP;
          end
        end
        ST_ACKWAIT: if (scl_fall) begin
          oe_q    <= ack_q;
          state_q <= ST_ACKDRV;
        end
        ST_ACKDRV: if (scl_fall) begin
          oe_q      <= 1'b0;
          state_q   <= after_q;
          cnt_q     <= '0;
          is_addr_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  AST_OE_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s); // R4
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (full_i || ovf_i)) |=> !ack_q); // R4
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> (!oe_q && !byte_done)); // R3
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              rw_clr,
  input  logic              rw_set,
  input  logic              pop,
  input  logic              ovf_clr,
  input  logic              irq_clr,
  output logic [BYTE_W-1:0] buf_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              rw_o
);
  logic [BYTE_W-1:0] buf_q;
  logic full_q, ovf_q, irq_q, rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
      rw_q   <= 1'b0;
    end else begin
      if (byte_done && !full_q) begin
        buf_q  <= byte_val;
        full_q <= 1'b1;
      end else if (pop) begin
        full_q <= 1'b0;
      end
      if (byte_done && full_q)  ovf_q <= 1'b1;
      else if (ovf_clr)         ovf_q <= 1'b0;
      if (byte_done)            irq_q <= 1'b1;
      else if (irq_clr)         irq_q <= 1'b0;
      if (rw_set)               rw_q  <= 1'b1;
      else if (rw_clr)          rw_q  <= 1'b0;
    end
  end

  assign buf_o  = buf_q;
  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign irq_o  = irq_q;
  assign rw_o   = rw_q;

  AST_FULL_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full_q) |=> (ovf_q && $stable(buf_q))); // R7
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !full_q) |=> (full_q && buf_q == $past(byte_val))); // R6
  AST_IRQ_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> irq_q); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R9
  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && full_q && !byte_done) |=> !full_q); // R8
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
  import i2c_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              ovf_o,
  input  logic              ovf_clr_i,
  output logic              irq_o,
  input  logic              irq_clr_i,
  output logic              rw_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, rw_clr, rw_set, full;
  logic [BYTE_W-1:0] byte_val;

  i2c_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr_i(dev_addr_i),
    .full_i(full), .ovf_i(ovf_o), .byte_done(byte_done), .byte_val(byte_val),
    .rw_clr(rw_clr), .rw_set(rw_set), .sda_oe(sda_oe_o)
  );

  i2c_rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_val(byte_val),
    .rw_clr(rw_clr), .rw_set(rw_set), .pop(rx_valid_o && rx_ready_i),
    .ovf_clr(ovf_clr_i), .irq_clr(irq_clr_i),
    .buf_o(rx_data_o), .full_o(full), .ovf_o(ovf_o), .irq_o(irq_o), .rw_o(rw_o)
  );

  assign rx_valid_o = full;
endmodule

// File: tb/test_i2c_rx_slave.sv
module test_i2c_rx_slave;
  localparam int QC = 4;
  localparam logic [6:0] DEV = 7'h5A;

  typedef struct packed {
    logic [7:0] first;
    logic [7:0] second;
    logic pop_mid, pop_end, clr_end;
    logic ack1, ack2;
    logic [7:0] exp_data;
    logic exp_full, exp_ovf, exp_irq, exp_rw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hB4, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'hB4, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB4, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'hB4, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h20, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hB5, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'hB4, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, rx_valid, rx_ready = 1'b0, ovf, ovf_clr = 1'b0, irq, irq_clr = 1'b0, rw;
  logic [7:0] rx_data;
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0, n_bad = 0;
  logic a1, a2;

  always #2.5 clk = ~clk;

  i2c_rx_slave i_i2c_rx_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .dev_addr_i(DEV), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .ovf_o(ovf), .ovf_clr_i(ovf_clr),
    .irq_o(irq), .irq_clr_i(irq_clr), .rw_o(rw)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * QC) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); seen = sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(d[i], s);
    send_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0; @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    chk("R8 reset valid", rx_valid, 0);
    chk("R9 reset ovf", ovf, 0);
    chk("R5 reset irq", irq, 0);
    chk("R4 reset oe", sda_oe, 0);
    rst_n = 1'b1;
    wq(2);

    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte(VECS[v].first, a1);
      if (VECS[v].pop_mid) pulse(rx_ready);
      send_byte(VECS[v].second, a2);
      bus_stop();
      chk("R4/R3 ack of first byte", a1, VECS[v].ack1);
      chk("R4/R6/R7 ack of second byte", a2, VECS[v].ack2);
      chk("R2/R6/R7/R10 buffer", rx_data, VECS[v].exp_data);
      chk("R8 full", rx_valid, VECS[v].exp_full);
      chk("R7/R9 ovf", ovf, VECS[v].exp_ovf);
      chk("R5/R3 irq", irq, VECS[v].exp_irq);
      chk("R2/R11 rw", rw, VECS[v].exp_rw);
      pulse(irq_clr);
      chk("R5 irq cleared", irq, 0);
      if (VECS[v].pop_end) begin
        pulse(rx_ready);
        chk("R8 pop clears full", rx_valid, 0);
        chk("R9 ovf survives pop", ovf, VECS[v].exp_ovf);
      end
      if (VECS[v].clr_end) begin
        pulse(ovf_clr);
        chk("R9 ovf cleared", ovf, 0);
      end
    end

    // R1: clock pulses without START are ignored
    send_byte(8'hB4, a1);
    send_byte(8'h77, a2);
    chk("R1 idle no ack", a1 | a2, 0);
    chk("R1 idle no store", rx_valid, 0);
    chk("R1 idle no irq", irq, 0);

    // R1: repeated START in the middle of a byte restarts the address phase
    bus_start();
    begin
      logic s;
      for (int i = 0; i < 4; i++) send_bit(1'b0, s);
    end
    bus_start();
    send_byte(8'hB4, a1);
    pulse(rx_ready);
    send_byte(8'hC3, a2);
    bus_stop();
    chk("R1 restart addr ack", a1, 1);
    chk("R1 restart data ack", a2, 1);
    chk("R1 restart data", rx_data, 8'hC3);

    // R1: STOP mid-frame returns to idle; further bytes ignored
    pulse(rx_ready);
    pulse(irq_clr);
    bus_start();
    begin
      logic s;
      send_bit(1'b1, s);
    end
    bus_stop();
    send_byte(8'hB4, a1);
    chk("R1 stop to idle", a1, 0);
    chk("R1 stop no irq", irq, 0);

    // R5 irq stays without clear across a second byte source
    bus_start();
    send_byte(8'hB4, a1);
    bus_stop();
    wq(4);
    chk("R5 irq held", irq, 1);
    chk("R2 addr stored", rx_data, 8'hB4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule